// File: doc/BRIEF.md
# Receive Buffer Status Write-Back Generator

This block follows one received Ethernet frame as it is spread over a chain of equal-size receive buffers. Each accepted input beat stands for one byte. The block counts bytes into the current buffer. It issues a descriptor write-back when that buffer fills or when the frame's last byte arrives. Every write-back carries the following fields:

- a descriptor index;
- a two-bit frame-position code;
- a summary error flag;
- the raw frame status;
- the number of bytes held in that buffer.

The summary error flag is built from a twelve-bit frame status vector. The upper three bits of that vector always count. Each of the lower nine bits can be suppressed by its own mask bit.

Write-backs leave through a registered valid/ready handshake. While a write-back waits for acceptance, the byte input is held off. The position code and the error flag therefore reach software only through the descriptor write-back. The configured buffer size must be at least one and is held steady while a frame is in progress.

Top module: `rxbuf_wb_gen`

## Requirements
- R1: A frame of no more bytes than the buffer size produces exactly one write-back with position code 2'b11.
- R2: A frame spanning N > 1 buffers produces these write-backs in order: code 2'b10, then N-2 write-backs of code 2'b00, then code 2'b01.
- R3: When a frame's last byte fills its buffer exactly, that write-back is the final one (code 2'b01 or 2'b11) and no further write-back follows for that frame.
- R4: The byte count equals the buffer size in every non-final write-back. In the final write-back it equals the bytes remaining, from 1 up to the buffer size.
- R5: The error flag is 1 in the final write-back whenever any of status bits 11, 10 or 9 is 1, whatever the mask.
- R6: For status bits 8..0, mask bit k set to 1 keeps status bit k out of the error flag, and mask bit k at 0 lets it set the flag. Without an unmasked active bit, the flag is 0.
- R7: Non-final write-backs (codes 2'b10 and 2'b00) report status 0 and error flag 0. The final write-back reports the status presented with the frame's last byte.
- R8: While a write-back is valid and not accepted, its fields stay unchanged and the byte input's ready is low.
- R9: The descriptor index starts at 0 and rises by one with each write-back, wrapping modulo 2^IDX_W.
- R10: After reset, no write-back is valid and the byte input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One received byte is offered |
| in_sof | input | 1 | The offered byte is the first of a frame |
| in_eof | input | 1 | The offered byte is the last of a frame |
| in_ready | output | 1 | The byte input can accept a beat |
| buf_size | input | CNT_W | Bytes per receive buffer (at least 1) |
| frame_status | input | 12 | Frame error status, sampled with the last byte |
| err_mask | input | 9 | Suppression mask for status bits 8..0 |
| wb_valid | output | 1 | A descriptor write-back is offered |
| wb_ready | input | 1 | The write-back is accepted |
| wb_index | output | IDX_W | Descriptor index |
| wb_pos | output | 2 | Frame-position code |
| wb_err | output | 1 | Summary error flag |
| wb_status | output | 12 | Raw frame status (zero unless final) |
| wb_count | output | CNT_W | Valid bytes in this buffer |

## Verification
Some properties are checked by assertions on every cycle:

- write-back fields hold steady under back-pressure;
- non-final write-backs carry zero status and a full byte count;
- the order of position codes across a frame's write-backs is legal;
- the three unmaskable status bits always raise the flag;
- the buffer fill counter stays below the buffer size.

Other properties can only be shown by the bench's scenarios: the exact number of write-backs for a given frame length, the final byte count, the effect of particular mask patterns, the absence of an empty trailing descriptor at an exact boundary, and index wrap-around.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  localparam int STAT_W = 12;
  localparam int MASK_W = 9;

  typedef enum logic [1:0] {
    POS_MID   = 2'b00,
    POS_LAST  = 2'b01,
    POS_FIRST = 2'b10,
    POS_ONLY  = 2'b11
  } pos_e;
endpackage

// File: rtl/rxwb_err_reduce.sv
module rxwb_err_reduce #(
  parameter int STAT_W = 12,
  parameter int MASK_W = 9
) (
  input  logic [STAT_W-1:0] status,
  input  logic [MASK_W-1:0] mask,
  output logic              err
);
  localparam int FIXED_W = STAT_W - MASK_W;

  logic [STAT_W-1:0] live;

  genvar g;
  generate
    for (g = 0; g < STAT_W; g++) begin : g_bit
      if (g < MASK_W) begin : g_maskable
        assign live[g] = status[g] & ~mask[g];
      end else begin : g_fixed
        assign live[g] = status[g];
      end
    end
  endgenerate

  assign err = |live;

  // R5
  always_comb begin
    if (FIXED_W > 0) begin
      fixed_bits_chk: assert (!(|status[STAT_W-1:MASK_W]) || err);
    end
  end
endmodule

// File: rtl/rxwb_seg_tracker.sv
module rxwb_seg_tracker
  import rxwb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  input  logic [CNT_W-1:0] buf_size,
  output logic             emit,
  output logic             is_final,
  output pos_e             pos,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] fill;
  logic             first_buf;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] next_fill;
  logic             first_now;
  logic             full;

  always_comb begin
    base      = sof ? '0 : fill;
    first_now = sof | first_buf;
    next_fill = base + 1'b1;
    full      = (next_fill == buf_size);
    emit      = beat & (eof | full);
    is_final  = eof;
    count     = next_fill;
    if (eof) pos = first_now ? POS_ONLY : POS_LAST;
    else     pos = first_now ? POS_FIRST : POS_MID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill      <= '0;
      first_buf <= 1'b1;
    end else if (beat) begin
      if (eof) begin
        fill      <= '0;
        first_buf <= 1'b1;
      end else if (full) begin
        fill      <= '0;
        first_buf <= 1'b0;
      end else begin
        fill      <= next_fill;
        first_buf <= first_now;
      end
    end
  end

  // R4
  fill_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    fill < buf_size);
endmodule

// File: rtl/rxbuf_wb_gen.sv
module rxbuf_wb_gen
  import rxwb_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic                 in_eof,
  output logic                 in_ready,
  input  logic [CNT_W-1:0]     buf_size,
  input  logic [STAT_W-1:0]    frame_status,
  input  logic [MASK_W-1:0]    err_mask,
  output logic                 wb_valid,
  input  logic                 wb_ready,
  output logic [IDX_W-1:0]     wb_index,
  output logic [1:0]           wb_pos,
  output logic                 wb_err,
  output logic [STAT_W-1:0]    wb_status,
  output logic [CNT_W-1:0]     wb_count
);
  logic             beat;
  logic             emit;
  logic             is_final;
  pos_e             seg_pos;
  logic [CNT_W-1:0] seg_count;
  logic             sum_err;
  logic [IDX_W-1:0] next_idx;

  assign in_ready = ~wb_valid;
  assign beat     = in_valid & in_ready;

  rxwb_seg_tracker #(.CNT_W(CNT_W)) seg_i (
    .clk      (clk),
    .rst      (rst),
    .beat     (beat),
    .sof      (in_sof),
    .eof      (in_eof),
    .buf_size (buf_size),
    .emit     (emit),
    .is_final (is_final),
    .pos      (seg_pos),
    .count    (seg_count)
  );

  rxwb_err_reduce #(.STAT_W(STAT_W), .MASK_W(MASK_W)) err_i (
    .status (frame_status),
    .mask   (err_mask),
    .err    (sum_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid  <= 1'b0;
      wb_index  <= '0;
      wb_pos    <= 2'b00;
      wb_err    <= 1'b0;
      wb_status <= '0;
      wb_count  <= '0;
      next_idx  <= '0;
    end else begin
      if (wb_valid && wb_ready) wb_valid <= 1'b0;
      if (emit) begin
        wb_valid  <= 1'b1;
        wb_index  <= next_idx;
        next_idx  <= next_idx + 1'b1;
        wb_pos    <= seg_pos;
        wb_err    <= is_final ? sum_err : 1'b0;
        wb_status <= is_final ? frame_status : '0;
        wb_count  <= seg_count;
      end
    end
  end

  // Checker state: a frame has an open (non-final) descriptor outstanding
  logic open_frame;
  always_ff @(posedge clk) begin
    if (rst) open_frame <= 1'b0;
    else if (wb_valid && wb_ready) open_frame <= ~wb_pos[0];
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_index) && $stable(wb_pos)
      && $stable(wb_err) && $stable(wb_status) && $stable(wb_count));

  // R7
  nonfinal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_pos[0] |-> wb_status == '0 && !wb_err);

  // R4
  nonfinal_full_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_pos[0] |-> wb_count == buf_size);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wb_count != '0 && wb_count <= buf_size);

  // R2
  order_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (open_frame ? !wb_pos[1] : wb_pos[1]));

  // R5
  fixed_err_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid && |wb_status[STAT_W-1:MASK_W] |-> wb_err);
endmodule

// File: tb/rxbuf_wb_gen_tb_top.sv
module rxbuf_wb_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int IDX_W = 4;
  localparam int NV = 9;

  localparam int V_LEN  [NV] = '{5, 16, 20, 3, 3, 1, 4, 9, 4};
  localparam int V_BSZ  [NV] = '{8, 8, 8, 8, 8, 1, 1, 4, 4};
  localparam int V_STAT [NV] = '{0, 0, 'h200, 'h004, 'h004, 0, 0, 'h800, 'h0FF};
  localparam int V_MASK [NV] = '{0, 0, 'h1FF, 'h004, 0, 0, 0, 'h1FF, 'h0F0};
  localparam int V_HOLD [NV] = '{0, 2, 0, 1, 0, 0, 3, 0, 1};

  logic clk = 0;
  logic rst;
  logic in_valid, in_sof, in_eof, in_ready;
  logic [CNT_W-1:0] buf_size;
  logic [11:0] frame_status;
  logic [8:0]  err_mask;
  logic wb_valid, wb_ready;
  logic [IDX_W-1:0] wb_index;
  logic [1:0] wb_pos;
  logic wb_err;
  logic [11:0] wb_status;
  logic [CNT_W-1:0] wb_count;

  int checks = 0;
  int errors = 0;
  int exp_idx = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbuf_wb_gen #(.CNT_W(CNT_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .buf_size(buf_size), .frame_status(frame_status),
    .err_mask(err_mask), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_index(wb_index), .wb_pos(wb_pos), .wb_err(wb_err),
    .wb_status(wb_status), .wb_count(wb_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_err(input int st, input int m);
    return ((st & 'hE00) != 0 || (st & 'h1FF & ~m) != 0) ? 1 : 0;
  endfunction

  task automatic send_frame(input int len, input int bsz, input int st,
                            input int m, input int hold);
    @(negedge clk);
    buf_size = CNT_W'(bsz);
    err_mask = 9'(m);
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (k == 1); in_eof = (k == len);
      frame_status = (k == len) ? 12'(st) : 12'h0;
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0;
      if (k == len || k % bsz == 0) begin
        automatic int bufn = (k - 1) / bsz;
        automatic bit fin = (k == len);
        automatic int epos = fin ? (bufn == 0 ? 3 : 1) : (bufn == 0 ? 2 : 0);
        automatic int ecnt = fin ? len - bufn * bsz : bsz;
        check("R3 wb_valid", wb_valid, 1);
        check(fin ? "R1/R2 final pos" : "R2 pos", wb_pos, epos);
        check("R4 count", wb_count, ecnt);
        check("R9 index", wb_index, exp_idx % (1 << IDX_W));
        check("R7 status", wb_status, fin ? st : 0);
        check("R5/R6 err", wb_err, fin ? exp_err(st, m) : 0);
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          check("R8 held valid", wb_valid, 1);
          check("R8 in_ready low", in_ready, 0);
          check("R8 pos stable", wb_pos, epos);
          check("R8 count stable", wb_count, ecnt);
        end
        wb_ready = 1;
        @(negedge clk);
        wb_ready = 0;
        check("R8 released", wb_valid, 0);
        exp_idx++;
      end else begin
        check("R4 no early wb", wb_valid, 0);
      end
    end
    repeat (2) begin
      @(negedge clk);
      check("R3 no trailing wb", wb_valid, 0);
    end
  endtask

  initial begin
    rst = 1; in_valid = 0; in_sof = 0; in_eof = 0; wb_ready = 0;
    buf_size = 8'd8; frame_status = 0; err_mask = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    check("R10 wb_valid", wb_valid, 0);
    check("R10 in_ready", in_ready, 1);
    // Table-driven scenarios
    for (int v = 0; v < NV; v++)
      send_frame(V_LEN[v], V_BSZ[v], V_STAT[v], V_MASK[v], V_HOLD[v]);
    // R6: single masked bit among others, masks on different lanes
    send_frame(2, 8, 'h001, 'h1FE, 0);
    send_frame(2, 8, 'h100, 'h100, 0);
    // R5: all maskable bits masked, fixed bit 10 active
    send_frame(6, 3, 'h400, 'h1FF, 1);
    // R10: reset in the middle of a frame clears pending write-back and index
    @(negedge clk);
    buf_size = 8'd2;
    in_valid = 1; in_sof = 1; in_eof = 0;
    @(negedge clk);
    in_sof = 0;
    @(negedge clk);
    in_valid = 0;
    check("R10 pending before reset", wb_valid, 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R10 wb cleared", wb_valid, 0);
    check("R10 ready after reset", in_ready, 1);
    exp_idx = 0;
    send_frame(3, 8, 0, 0, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule